// File: doc/BRIEF.md
# Parity Transceiver with Error Latch

This block links an 8-bit data bus (side A) with a 9-bit bus (side B) that carries the same eight data bits plus one parity bit. Two active-low enables select how data moves:

- Only the B enable low: A data goes out on B, with an odd parity bit added.
- Only the A enable low: B data bits go out on A.
- Neither enable low: neither bus is driven.
- Both enables low: A data goes out on B with the parity bit inverted. This deliberately corrupts the word so that the error path can be exercised.

Each bus pin group is modelled as separate in, out and drive-enable signals.

A checker always examines the nine bits present on the B side. That is the driven word whenever B is an output, and the received word otherwise. It reports an even count of ones as a parity error. The error result reaches the active-low error output through a latch with two controls:

- An active-low pass control makes the latch follow the checker.
- An active-low clear input forces the no-error state.

The stored value is captured on the clock edges at which pass is low. It is held while pass stays high.

Top module: `ptx_parity_xcvr`

## Requirements
- R1: `b_oe` is 1 exactly when `b_en_n` is 0. `a_oe` is 1 exactly when `a_en_n` is 0 and `b_en_n` is 1.
- R2: With `b_en_n`=0 and `a_en_n`=1, `b_data_out` equals `a_in`, and `b_par_out` makes the 9-bit count of ones odd.
- R3: With `a_en_n`=0 and `b_en_n`=1, `a_out` equals `b_data_in`.
- R4: With both enables at 1, `a_oe` and `b_oe` are both 0.
- R5: With both enables at 0, `b_data_out` equals `a_in`, and `b_par_out` is the inverse of the odd parity bit, so the 9-bit count of ones is even.
- R6: With `pass_n`=0 and `clr_n`=1, `err_n` is 0 exactly when the B-side word has an even number of ones. The B-side word is {`b_data_out`,`b_par_out`} when `b_en_n`=0, and {`b_data_in`,`b_par_in`} otherwise.
- R7: Each clock edge with `pass_n`=0 and `clr_n`=1 stores the current check result. While `pass_n`=1, `err_n` shows the stored result and ignores changes on the buses.
- R8: While `clr_n`=0, `err_n` is 1. A clock edge with `clr_n`=0 sets the stored result to no-error, and this takes priority over `pass_n`.
- R9: After reset the stored result is no-error, so `err_n` is 1 while `pass_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the error store |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_en_n | input | 1 | Active-low enable for driving side A |
| b_en_n | input | 1 | Active-low enable for driving side B |
| pass_n | input | 1 | Active-low latch pass control |
| clr_n | input | 1 | Active-low clear of the error latch |
| a_in | input | 8 | Data received on side A |
| a_out | output | 8 | Data driven on side A |
| a_oe | output | 1 | Drive enable for side A |
| b_data_in | input | 8 | Data bits received on side B |
| b_par_in | input | 1 | Parity bit received on side B |
| b_data_out | output | 8 | Data bits driven on side B |
| b_par_out | output | 1 | Parity bit driven on side B |
| b_oe | output | 1 | Drive enable for side B |
| err_n | output | 1 | Active-low parity error flag |

## Verification
Bus outputs, drive enables, and the error output in pass or clear mode are combinational. They are due in the same cycle as the stimulus, so the bench samples them two time units after it changes inputs on the falling edge. The stored result changes only at the rising edge that follows a cycle with pass or clear active. The bench's reference model therefore updates its stored flag at each rising edge, using the inputs held across that edge. The hold check reads the output one half cycle later, after the buses have been changed to a word with the opposite parity.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
  parameter int unsigned DATA_W = 8;
  localparam int unsigned WORD_W = DATA_W + 1;

  typedef enum logic [1:0] {
    MODE_ISOLATE = 2'b00,
    MODE_A_TO_B  = 2'b01,
    MODE_B_TO_A  = 2'b10,
    MODE_FORCE   = 2'b11
  } xfer_mode_t;

  // returns 1 when the word holds an even number of ones (odd-parity violation)
  function automatic logic word_is_even(input logic [WORD_W-1:0] w);
    return ~(^w);
  endfunction
endpackage

// File: rtl/ptx_dir_ctrl.sv
module ptx_dir_ctrl
  import ptx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       a_en_n,
  input  logic       b_en_n,
  output xfer_mode_t mode,
  output logic       a_oe,
  output logic       b_oe
);
  always_comb begin
    unique case ({a_en_n, b_en_n})
      2'b11:   mode = MODE_ISOLATE;
      2'b10:   mode = MODE_A_TO_B;
      2'b01:   mode = MODE_B_TO_A;
      default: mode = MODE_FORCE;
    endcase
  end

  always_comb begin
    a_oe = (mode == MODE_B_TO_A);
    b_oe = (mode == MODE_A_TO_B) || (mode == MODE_FORCE);
  end

  AST_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en_n && b_en_n) |-> (!a_oe && !b_oe)); // R4
  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_oe && b_oe)); // R1
endmodule

// File: rtl/ptx_par_gen.sv
module ptx_par_gen
  import ptx_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  input  logic              invert,
  output logic              par
);
  logic odd_bit;
  always_comb begin
    odd_bit = ~(^data);
    par     = odd_bit ^ invert;
  end
endmodule

// File: rtl/ptx_err_latch.sv
module ptx_err_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic live_err,
  input  logic pass_n,
  input  logic clr_n,
  output logic err_n
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       held_err_q, held_err_d;
  logic       held_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    held_en    = !clr_n || !pass_n;
    held_err_d = clr_n ? live_err : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   held_err_q <= 1'b0;
    else if (held_en) held_err_q <= held_err_d;
  end

  always_comb begin
    if (!clr_n)       err_n = 1'b1;
    else if (!pass_n) err_n = !live_err;
    else              err_n = !held_err_q;
  end

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pass_n) && $past(clr_n) && pass_n && clr_n) |-> (err_n == $past(err_n))); // R7
  AST_CLR_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> err_n); // R8
  AST_CLR_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!clr_n) && pass_n && clr_n) |-> err_n); // R8
endmodule

// File: rtl/ptx_parity_xcvr.sv
module ptx_parity_xcvr
  import ptx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_en_n,
  input  logic              b_en_n,
  input  logic              pass_n,
  input  logic              clr_n,
  input  logic [DATA_W-1:0] a_in,
  output logic [DATA_W-1:0] a_out,
  output logic              a_oe,
  input  logic [DATA_W-1:0] b_data_in,
  input  logic              b_par_in,
  output logic [DATA_W-1:0] b_data_out,
  output logic              b_par_out,
  output logic              b_oe,
  output logic              err_n
);
  xfer_mode_t        mode;
  logic              gen_par;
  logic [WORD_W-1:0] chk_word;
  logic              live_err;

  ptx_dir_ctrl i_dir (
    .clk(clk), .rst_n(rst_n), .a_en_n(a_en_n), .b_en_n(b_en_n),
    .mode(mode), .a_oe(a_oe), .b_oe(b_oe)
  );

  ptx_par_gen i_gen (
    .data(a_in), .invert(mode == MODE_FORCE), .par(gen_par)
  );

  always_comb begin
    a_out      = b_data_in;
    b_data_out = a_in;
    b_par_out  = gen_par;
    chk_word   = b_oe ? {a_in, gen_par} : {b_data_in, b_par_in};
    live_err   = word_is_even(chk_word);
  end

  ptx_err_latch i_latch (
    .clk(clk), .rst_n(rst_n), .live_err(live_err),
    .pass_n(pass_n), .clr_n(clr_n), .err_n(err_n)
  );

  AST_ODD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (!b_en_n && a_en_n) |-> (b_oe && (^{b_data_out, b_par_out}))); // R2
  AST_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    (!b_en_n && !a_en_n) |-> (b_oe && !(^{b_data_out, b_par_out}))); // R5
  AST_B_TO_A: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_en_n && b_en_n) |-> (a_oe && a_out == b_data_in)); // R3
  AST_PASS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass_n && clr_n && b_oe) |-> (err_n == (^{b_data_out, b_par_out}))); // R6
endmodule

// File: tb/test_ptx_parity_xcvr.sv
module test_ptx_parity_xcvr;
  logic clk = 1'b0;
  logic rst_n;
  logic a_en_n, b_en_n, pass_n, clr_n;
  logic [7:0] a_in, b_data_in, a_out, b_data_out;
  logic b_par_in, a_oe, b_oe, b_par_out, err_n;

  int total = 0;
  int bad = 0;
  bit m_err;        // model stored error
  bit done = 0;

  always #4 clk = ~clk;

  ptx_parity_xcvr i_ptx_parity_xcvr (
    .clk(clk), .rst_n(rst_n), .a_en_n(a_en_n), .b_en_n(b_en_n),
    .pass_n(pass_n), .clr_n(clr_n), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_data_in(b_data_in), .b_par_in(b_par_in), .b_data_out(b_data_out),
    .b_par_out(b_par_out), .b_oe(b_oe), .err_n(err_n)
  );

  function automatic bit ones_odd(input logic [8:0] w);
    int n = 0;
    for (int i = 0; i < 9; i++) if (w[i]) n++;
    return (n % 2) == 1;
  endfunction

  function automatic bit m_par();
    bit p = !ones_odd({1'b0, a_in});
    if (!a_en_n && !b_en_n) p = !p;
    return p;
  endfunction

  function automatic bit m_live_err();
    logic [8:0] w;
    if (!b_en_n) w = {a_in, m_par()};
    else         w = {b_data_in, b_par_in};
    return !ones_odd(w);
  endfunction

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string err_tag);
    bit exp_err_n;
    chk("R1 a_oe", {8'd0, a_oe}, {8'd0, (!a_en_n && b_en_n)});
    chk("R1 b_oe", {8'd0, b_oe}, {8'd0, !b_en_n});
    if (a_en_n && b_en_n) chk("R4 isolate", {7'd0, a_oe, b_oe}, 9'd0);
    if (!a_en_n && b_en_n) chk("R3 a_out", {1'b0, a_out}, {1'b0, b_data_in});
    if (!b_en_n) begin
      if (!a_en_n) chk("R5 forced word", {b_data_out, b_par_out}, {a_in, m_par()});
      else         chk("R2 word", {b_data_out, b_par_out}, {a_in, m_par()});
    end
    if (!clr_n)       exp_err_n = 1'b1;
    else if (!pass_n) exp_err_n = !m_live_err();
    else              exp_err_n = !m_err;
    chk(err_tag, {8'd0, err_n}, {8'd0, exp_err_n});
  endtask

  // apply inputs at the falling edge, check, then let the rising edge update the model
  task automatic step(input logic ae, input logic be, input logic ps, input logic cl,
                      input logic [7:0] a, input logic [7:0] b, input logic bp,
                      input string err_tag);
    @(negedge clk);
    a_en_n = ae; b_en_n = be; pass_n = ps; clr_n = cl;
    a_in = a; b_data_in = b; b_par_in = bp;
    #2;
    check_all(err_tag);
    @(posedge clk);
    if (!clr_n)       m_err = 1'b0;
    else if (!pass_n) m_err = m_live_err();
  endtask

  initial begin
    #1500000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; a_en_n = 1; b_en_n = 1; pass_n = 1; clr_n = 1;
    a_in = 0; b_data_in = 0; b_par_in = 0; m_err = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) step(1, 1, 1, 1, 8'h00, 8'h00, 1'b0, "R9 reset err_n");

    // R6: erroneous received word in pass mode, B to A
    step(0, 1, 0, 1, 8'h03, 8'h03, 1'b0, "R6 bad word");
    // R7: hold after pass released, bus changed to a good word
    step(0, 1, 1, 1, 8'h03, 8'h03, 1'b1, "R7 hold error");
    step(1, 1, 1, 1, 8'h5a, 8'h01, 1'b0, "R7 hold error");
    // R8: clear overrides pass, then held state is no-error
    step(0, 1, 0, 0, 8'h00, 8'h00, 1'b0, "R8 clear active");
    step(1, 1, 1, 1, 8'h00, 8'h00, 1'b0, "R8 cleared store");
    // R5: forced inverted parity seen as error by the checker
    step(0, 0, 0, 1, 8'hff, 8'h00, 1'b1, "R5 R6 forced error");
    step(0, 0, 1, 1, 8'h00, 8'h00, 1'b1, "R7 hold forced error");
    // R2: generated word is good
    step(1, 0, 0, 1, 8'h80, 8'h00, 1'b0, "R2 R6 generated ok");

    for (int k = 0; k < 3000; k++) begin
      logic [3:0] c = 4'($urandom);
      step(c[0], c[1], c[2], ($urandom % 8) != 0, 8'($urandom), 8'($urandom),
           1'($urandom), "R6 R7 R8 random err_n");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule